// File: doc/BRIEF.md
# Partitioned Store Buffer with Byte-Merging Load Forwarding

This block sits between a core's retirement stage and its data cache. Retired stores are queued here with their doubleword address, a byte-enable mask and 64 bits of data. They are presented to the cache one at a time, oldest first within each hardware thread, over a valid/ready handshake. Until the cache accepts a store, the store is visible only to loads of the thread that issued it.

A load presents its address, the bytes it wants and the cache's read data in the same cycle. The block builds the result one byte at a time. Each requested byte comes from the youngest queued store of the same thread that writes that byte. Every other byte comes from the cache data. A per-byte mask shows which bytes came from the buffer. A forwarding-kind code tells a full forward (one store supplies every requested byte) apart from a merged result.

A StoreLoad fence holds the thread's later loads and stores until that thread's entries have all committed. Uncacheable loads never forward: they wait until their thread has nothing queued. With one thread active, thread 0 owns all sixteen entries. With two threads active, the entries are split into two fixed halves of eight.

Top module: `store_buffer_fwd`

## Requirements
- R1: Capacity. With `smtMode`=1 each thread owns 8 entries. With `smtMode`=0 thread 0 owns 16 entries and thread 1 owns none, so `enqFull[1]` stays 1. `enqFull[t]` is 1 exactly when thread t's share is occupied. A store presented while `enqFull[t]` or `fenceBusy[t]` is 1 is dropped.
- R2: Commit. `cmtValid` is 1 whenever any entry is queued. The presented store is the oldest one of thread `cmtThread`, so each thread commits in program order. While `cmtReady` is 0 the presented fields hold stable, and the entry is freed only on a cycle with `cmtValid` and `cmtReady` both 1. With `smtMode`=0, `cmtThread` is 0.
- R3: Full forward. When a single queued store of the load's thread, at the same address, writes every byte set in `ldBe`, and no younger store overrides any of them, those bytes come from that store, `ldFwdMask` equals `ldBe` and `ldKind` is 2.
- R4: Merge. When only some requested bytes are written by queued stores, those bytes come from the buffer and the rest from `cacheRdData`. The same holds when the requested bytes come from more than one store. In both cases `ldKind` is 1 and `ldFwdMask` marks the buffer bytes. Byte b is bits [8b+7:8b] and is selected by enable bit b.
- R5: Youngest wins. When several queued stores write the same byte, the most recently enqueued one supplies it.
- R6: No match. When no queued store of the thread writes any requested byte, `ldData` equals `cacheRdData`, `ldFwdMask` is 0 and `ldKind` is 0. `ldFwdMask` is never set for a byte outside `ldBe`.
- R7: Thread isolation. A load searches only entries of its own thread. Stores of the other thread never set `ldFwdMask`.
- R8: Fence. A `fenceValid` pulse for thread t sets `fenceBusy[t]` on the next cycle if t still has entries queued. While it is set, loads of thread t get `ldStall`=1 with `ldFwdMask`=0 and stores of thread t are dropped. It clears on the cycle after t's last entry commits, after which a reload of the same address sees only cache data.
- R9: Uncacheable loads. A load with `ldUncached`=1 never forwards: `ldFwdMask` is 0 and `ldData` equals `cacheRdData`. `ldStall` is 1 while its thread has any entry queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smtMode | input | 1 | 1: two threads, split entries; 0: thread 0 only |
| enqValid | input | 1 | Store enqueue request |
| enqThread | input | 1 | Thread of the store |
| enqAddr | input | 32 | Doubleword address of the store |
| enqBe | input | 8 | Byte enables of the store |
| enqData | input | 64 | Store data |
| enqFull | output | 2 | Per-thread share full |
| fenceValid | input | 1 | StoreLoad fence pulse |
| fenceThread | input | 1 | Thread of the fence |
| fenceBusy | output | 2 | Per-thread fence drain in progress |
| ldValid | input | 1 | Load lookup valid |
| ldThread | input | 1 | Thread of the load |
| ldUncached | input | 1 | Load is uncacheable |
| ldAddr | input | 32 | Doubleword address of the load |
| ldBe | input | 8 | Requested bytes |
| cacheRdData | input | 64 | Cache data for the load, same cycle |
| ldStall | output | 1 | Load must be retried later |
| ldData | output | 64 | Merged load result |
| ldFwdMask | output | 8 | Bytes supplied by the buffer |
| ldKind | output | 2 | 0 none, 1 merge, 2 full forward |
| cmtValid | output | 1 | A store is offered to the cache |
| cmtReady | input | 1 | Cache accepts the offered store |
| cmtThread | output | 1 | Thread of the offered store |
| cmtAddr | output | 32 | Address of the offered store |
| cmtBe | output | 8 | Byte enables of the offered store |
| cmtData | output | 64 | Data of the offered store |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of the queue contents. The offered commit holds steady while it waits. The forward mask stays inside the load's enables and is empty for uncacheable or fenced loads. The forwarding kind agrees with the mask. Thread 1 has no share in single-thread mode, and the mode changes only when the buffer is empty. Only the bench scenarios can show which store's bytes end up in the result. Those scenarios cover youngest-store priority, the difference between full forward and merge, isolation between threads, commit order per thread, the capacity limits in both modes, and that a reload after a fence sees only cache data.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int SB_DEPTH  = 16;
  parameter int SB_DATA_W = 64;
  parameter int SB_ADDR_W = 32;
  localparam int SB_BYTES = SB_DATA_W / 8;
  localparam int SB_HALF  = SB_DEPTH / 2;
  localparam int IDX_W    = $clog2(SB_DEPTH);
  localparam int CNT_W    = IDX_W + 1;

  typedef enum logic [1:0] {
    FWD_NONE  = 2'd0,
    FWD_MERGE = 2'd1,
    FWD_FULL  = 2'd2
  } fwdKind_e;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic             lkEn;
    logic [CNT_W-1:0] lkBase;
    logic [CNT_W-1:0] lkCap;
    logic [CNT_W-1:0] lkHead;
    logic [CNT_W-1:0] lkCount;
  } sbStrobe_t;
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       smtMode,
  input  logic       enqValid,
  input  logic       enqThread,
  input  logic       fenceValid,
  input  logic       fenceThread,
  input  logic       ldValid,
  input  logic       ldThread,
  input  logic       ldUncached,
  input  logic       cmtReady,
  output logic [1:0] enqFull,
  output logic [1:0] fenceBusy,
  output logic       ldStall,
  output logic       cmtValid,
  output logic       cmtThread,
  output sbStrobe_t  strobe
);
  logic [CNT_W-1:0] head [2];
  logic [CNT_W-1:0] tail [2];
  logic [CNT_W-1:0] count [2];
  logic [CNT_W-1:0] countNext [2];
  logic [CNT_W-1:0] cap [2];
  logic [CNT_W-1:0] base [2];
  logic [1:0] nonEmpty, enqHit, popHit, fencePend;
  logic enqOk, cmtFire, selThread, rrPtr, holdValid, holdThread;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] p,
                                             input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] n;
    n = p + 1'b1;
    return (n == c) ? '0 : n;
  endfunction

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      if (smtMode) begin
        cap[t]  = CNT_W'(SB_HALF);
        base[t] = CNT_W'(t * SB_HALF);
      end else begin
        cap[t]  = (t == 0) ? CNT_W'(SB_DEPTH) : '0;
        base[t] = '0;
      end
      enqFull[t]  = (count[t] == cap[t]);
      nonEmpty[t] = (count[t] != '0);
    end
  end

  assign fenceBusy = fencePend;
  assign enqOk     = enqValid && !enqFull[enqThread] && !fencePend[enqThread];

  // commit arbitration: a waiting offer keeps its thread until accepted
  always_comb begin
    if (holdValid)             selThread = holdThread;
    else if (nonEmpty[rrPtr])  selThread = rrPtr;
    else                       selThread = ~rrPtr;
  end

  assign cmtValid  = |nonEmpty;
  assign cmtThread = selThread;
  assign cmtFire   = cmtValid && cmtReady;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      enqHit[t] = enqOk && (enqThread == t[0]);
      popHit[t] = cmtFire && (selThread == t[0]);
      countNext[t] = count[t] + CNT_W'(enqHit[t]) - CNT_W'(popHit[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr      <= 1'b0;
      holdValid  <= 1'b0;
      holdThread <= 1'b0;
      fencePend  <= '0;
      for (int t = 0; t < 2; t++) begin
        head[t]  <= '0;
        tail[t]  <= '0;
        count[t] <= '0;
      end
    end else begin
      holdValid  <= cmtValid && !cmtReady;
      holdThread <= selThread;
      if (cmtFire) rrPtr <= ~selThread;
      for (int t = 0; t < 2; t++) begin
        count[t] <= countNext[t];
        if (countNext[t] == '0) begin
          head[t] <= '0;
          tail[t] <= '0;
        end else begin
          if (enqHit[t]) tail[t] <= bump(tail[t], cap[t]);
          if (popHit[t]) head[t] <= bump(head[t], cap[t]);
        end
        fencePend[t] <= (fencePend[t] || (fenceValid && fenceThread == t[0]))
                        && (countNext[t] != '0);
      end
    end
  end

  assign ldStall = ldValid && (fencePend[ldThread] ||
                               (ldUncached && nonEmpty[ldThread]));

  always_comb begin
    strobe.wrEn    = enqOk;
    strobe.wrIdx   = IDX_W'(base[enqThread] + tail[enqThread]);
    strobe.rdIdx   = IDX_W'(base[selThread] + head[selThread]);
    strobe.lkEn    = ldValid && !ldUncached && !ldStall;
    strobe.lkBase  = base[ldThread];
    strobe.lkCap   = cap[ldThread];
    strobe.lkHead  = head[ldThread];
    strobe.lkCount = count[ldThread];
  end
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
(
  input  logic                 clk,
  input  sbStrobe_t            strobe,
  input  logic [SB_ADDR_W-1:0] enqAddr,
  input  logic [SB_BYTES-1:0]  enqBe,
  input  logic [SB_DATA_W-1:0] enqData,
  input  logic [SB_ADDR_W-1:0] ldAddr,
  input  logic [SB_BYTES-1:0]  ldBe,
  input  logic [SB_DATA_W-1:0] cacheRdData,
  output logic [SB_ADDR_W-1:0] cmtAddr,
  output logic [SB_BYTES-1:0]  cmtBe,
  output logic [SB_DATA_W-1:0] cmtData,
  output logic [SB_DATA_W-1:0] ldData,
  output logic [SB_BYTES-1:0]  ldFwdMask,
  output fwdKind_e             ldKind
);
  logic [SB_ADDR_W-1:0] addrMem [SB_DEPTH];
  logic [SB_BYTES-1:0]  beMem   [SB_DEPTH];
  logic [SB_DATA_W-1:0] dataMem [SB_DEPTH];
  logic [SB_BYTES*IDX_W-1:0] srcFlat;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      addrMem[strobe.wrIdx] <= enqAddr;
      beMem[strobe.wrIdx]   <= enqBe;
      dataMem[strobe.wrIdx] <= enqData;
    end
  end

  assign cmtAddr = addrMem[strobe.rdIdx];
  assign cmtBe   = beMem[strobe.rdIdx];
  assign cmtData = dataMem[strobe.rdIdx];

  // one lane per byte: scan oldest to youngest, last match wins
  for (genvar b = 0; b < SB_BYTES; b++) begin : g_lane
    logic             laneHit;
    logic [IDX_W-1:0] laneSrc;
    logic [CNT_W-1:0] pos;
    logic [IDX_W-1:0] idx;

    always_comb begin
      laneHit = 1'b0;
      laneSrc = '0;
      pos     = '0;
      idx     = '0;
      for (int k = 0; k < SB_DEPTH; k++) begin
        if (CNT_W'(k) < strobe.lkCount) begin
          pos = strobe.lkHead + CNT_W'(k);
          if (pos >= strobe.lkCap) pos = pos - strobe.lkCap;
          idx = IDX_W'(strobe.lkBase + pos);
          if (addrMem[idx] == ldAddr && beMem[idx][b]) begin
            laneHit = 1'b1;
            laneSrc = idx;
          end
        end
      end
    end

    assign ldFwdMask[b] = laneHit && strobe.lkEn && ldBe[b];
    assign srcFlat[b*IDX_W +: IDX_W] = laneSrc;
    assign ldData[b*8 +: 8] = ldFwdMask[b] ? dataMem[laneSrc][b*8 +: 8]
                                           : cacheRdData[b*8 +: 8];
  end

  always_comb begin
    logic             single;
    logic             seen;
    logic [IDX_W-1:0] firstSrc;
    single   = 1'b1;
    seen     = 1'b0;
    firstSrc = '0;
    for (int b = 0; b < SB_BYTES; b++) begin
      if (ldFwdMask[b]) begin
        if (!seen) begin
          seen     = 1'b1;
          firstSrc = srcFlat[b*IDX_W +: IDX_W];
        end else if (srcFlat[b*IDX_W +: IDX_W] != firstSrc) begin
          single = 1'b0;
        end
      end
    end
    if (ldFwdMask == '0)                  ldKind = FWD_NONE;
    else if (single && ldFwdMask == ldBe) ldKind = FWD_FULL;
    else                                  ldKind = FWD_MERGE;
  end
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd
  import sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 smtMode,
  input  logic                 enqValid,
  input  logic                 enqThread,
  input  logic [SB_ADDR_W-1:0] enqAddr,
  input  logic [SB_BYTES-1:0]  enqBe,
  input  logic [SB_DATA_W-1:0] enqData,
  output logic [1:0]           enqFull,
  input  logic                 fenceValid,
  input  logic                 fenceThread,
  output logic [1:0]           fenceBusy,
  input  logic                 ldValid,
  input  logic                 ldThread,
  input  logic                 ldUncached,
  input  logic [SB_ADDR_W-1:0] ldAddr,
  input  logic [SB_BYTES-1:0]  ldBe,
  input  logic [SB_DATA_W-1:0] cacheRdData,
  output logic                 ldStall,
  output logic [SB_DATA_W-1:0] ldData,
  output logic [SB_BYTES-1:0]  ldFwdMask,
  output logic [1:0]           ldKind,
  output logic                 cmtValid,
  input  logic                 cmtReady,
  output logic                 cmtThread,
  output logic [SB_ADDR_W-1:0] cmtAddr,
  output logic [SB_BYTES-1:0]  cmtBe,
  output logic [SB_DATA_W-1:0] cmtData
);
  sbStrobe_t strobe;
  fwdKind_e  kind;

  sb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .smtMode(smtMode),
    .enqValid(enqValid), .enqThread(enqThread),
    .fenceValid(fenceValid), .fenceThread(fenceThread),
    .ldValid(ldValid), .ldThread(ldThread), .ldUncached(ldUncached),
    .cmtReady(cmtReady), .enqFull(enqFull), .fenceBusy(fenceBusy),
    .ldStall(ldStall), .cmtValid(cmtValid), .cmtThread(cmtThread),
    .strobe(strobe)
  );

  sb_datapath u_dp (
    .clk(clk), .strobe(strobe),
    .enqAddr(enqAddr), .enqBe(enqBe), .enqData(enqData),
    .ldAddr(ldAddr), .ldBe(ldBe), .cacheRdData(cacheRdData),
    .cmtAddr(cmtAddr), .cmtBe(cmtBe), .cmtData(cmtData),
    .ldData(ldData), .ldFwdMask(ldFwdMask), .ldKind(kind)
  );

  assign ldKind = kind;
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 smtMode,
  input logic [1:0]           enqFull,
  input logic [1:0]           fenceBusy,
  input logic                 ldValid,
  input logic                 ldThread,
  input logic                 ldUncached,
  input logic [SB_BYTES-1:0]  ldBe,
  input logic                 ldStall,
  input logic [SB_BYTES-1:0]  ldFwdMask,
  input logic [1:0]           ldKind,
  input logic                 cmtValid,
  input logic                 cmtReady,
  input logic                 cmtThread,
  input logic [SB_ADDR_W-1:0] cmtAddr,
  input logic [SB_BYTES-1:0]  cmtBe,
  input logic [SB_DATA_W-1:0] cmtData
);
  AST_CMT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && !cmtReady |=> cmtValid && $stable(cmtThread) && $stable(cmtAddr)
                             && $stable(cmtBe) && $stable(cmtData)); // R2
  AST_CMT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && !smtMode |-> !cmtThread); // R2
  AST_T1_NO_SHARE: assert property (@(posedge clk) disable iff (!rstN)
    !smtMode |-> enqFull[1]); // R1
  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(smtMode) |-> !cmtValid); // R1
  AST_MASK_IN_BE: assert property (@(posedge clk) disable iff (!rstN)
    (ldFwdMask & ~ldBe) == '0); // R6
  AST_FULL_KIND: assert property (@(posedge clk) disable iff (!rstN)
    ldKind == 2'd2 |-> ldFwdMask == ldBe && ldBe != '0); // R3
  AST_MERGE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    ldKind == 2'd1 |-> ldFwdMask != '0); // R4
  AST_NONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    ldKind == 2'd0 |-> ldFwdMask == '0); // R6
  AST_FENCE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && fenceBusy[ldThread] |-> ldStall && ldFwdMask == '0); // R8
  AST_UC_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && ldUncached |-> ldFwdMask == '0); // R9
endmodule

bind store_buffer_fwd sb_checker u_chk (.*);

// File: tb/store_buffer_fwd_tb.sv
module store_buffer_fwd_tb;
  logic        clk = 1'b0;
  logic        rstN, smtMode;
  logic        enqValid, enqThread;
  logic [31:0] enqAddr;
  logic [7:0]  enqBe;
  logic [63:0] enqData;
  logic [1:0]  enqFull, fenceBusy, ldKind;
  logic        fenceValid, fenceThread;
  logic        ldValid, ldThread, ldUncached, ldStall;
  logic [31:0] ldAddr;
  logic [7:0]  ldBe, ldFwdMask;
  logic [63:0] cacheRdData, ldData;
  logic        cmtValid, cmtReady, cmtThread;
  logic [31:0] cmtAddr;
  logic [7:0]  cmtBe;
  logic [63:0] cmtData;

  int checks = 0;
  int failures = 0;

  // bench model: per-thread queues, index 0 oldest
  logic [31:0] mAddr [2][16];
  logic [7:0]  mBe   [2][16];
  logic [63:0] mData [2][16];
  int          mCnt  [2];
  bit          fenceExp [2];

  always #4 clk = ~clk;

  store_buffer_fwd u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int capOf(input int t);
    if (smtMode) return 8;
    return (t == 0) ? 16 : 0;
  endfunction

  task automatic doEnq(input int t, input logic [31:0] a, input logic [7:0] be,
                       input logic [63:0] d);
    bit expFull;
    @(negedge clk);
    enqValid = 1'b1; enqThread = t[0]; enqAddr = a; enqBe = be; enqData = d;
    #1;
    expFull = (mCnt[t] == capOf(t));
    chk(enqFull[t] == expFull, "R1 enqFull", 64'(enqFull[t]), 64'(expFull));
    @(posedge clk); #1;
    enqValid = 1'b0;
    if (!expFull && !fenceExp[t]) begin
      mAddr[t][mCnt[t]] = a; mBe[t][mCnt[t]] = be; mData[t][mCnt[t]] = d;
      mCnt[t]++;
    end
  endtask

  task automatic doLoad(input string tag, input int t, input logic [31:0] a,
                        input logic [7:0] be, input bit uc, input logic [63:0] cache);
    logic [63:0] eData;
    logic [7:0]  eMask;
    logic [1:0]  eKind;
    int          src [8];
    bit          eStall, single;
    int          first;
    @(negedge clk);
    ldValid = 1'b1; ldThread = t[0]; ldAddr = a; ldBe = be; ldUncached = uc;
    cacheRdData = cache;
    #1;
    eStall = fenceExp[t] || (uc && mCnt[t] != 0);
    eData = cache; eMask = '0;
    for (int b = 0; b < 8; b++) src[b] = -1;
    if (!eStall && !uc) begin
      for (int k = 0; k < mCnt[t]; k++)
        for (int b = 0; b < 8; b++)
          if (mAddr[t][k] == a && mBe[t][k][b] && be[b]) begin
            eData[b*8 +: 8] = mData[t][k][b*8 +: 8];
            eMask[b] = 1'b1;
            src[b] = k;
          end
    end
    single = 1'b1; first = -1;
    for (int b = 0; b < 8; b++)
      if (eMask[b]) begin
        if (first < 0) first = src[b];
        else if (src[b] != first) single = 1'b0;
      end
    if (eMask == '0) eKind = 2'd0;
    else if (single && eMask == be) eKind = 2'd2;
    else eKind = 2'd1;
    chk(ldStall == eStall, {tag, " stall"}, 64'(ldStall), 64'(eStall));
    chk(ldData == eData, {tag, " data"}, ldData, eData);
    chk(ldFwdMask == eMask, {tag, " mask"}, 64'(ldFwdMask), 64'(eMask));
    chk(ldKind == eKind, {tag, " kind"}, 64'(ldKind), 64'(eKind));
    @(posedge clk); #1;
    ldValid = 1'b0; ldUncached = 1'b0;
  endtask

  task automatic doFence(input int t);
    @(negedge clk);
    fenceValid = 1'b1; fenceThread = t[0];
    @(posedge clk); #1;
    fenceValid = 1'b0;
    fenceExp[t] = (mCnt[t] != 0);
    chk(fenceBusy[t] == fenceExp[t], "R8 fenceBusy set", 64'(fenceBusy[t]),
        64'(fenceExp[t]));
  endtask

  // R2: every offered store must be the oldest of its thread
  task automatic drainAll();
    int th;
    while (mCnt[0] + mCnt[1] > 0) begin
      @(negedge clk);
      cmtReady = 1'b1;
      #1;
      th = int'(cmtThread);
      chk(cmtValid == 1'b1, "R2 cmtValid", 64'(cmtValid), 64'd1);
      chk(smtMode || th == 0, "R2 single-mode thread", 64'(th), 64'd0);
      if (mCnt[th] == 0) begin
        chk(1'b0, "R2 thread has entry", 64'(th), 64'(mCnt[th]));
        break;
      end
      chk(cmtAddr == mAddr[th][0] && cmtBe == mBe[th][0] && cmtData == mData[th][0],
          "R2 commit order", cmtData, mData[th][0]);
      for (int k = 1; k < mCnt[th]; k++) begin
        mAddr[th][k-1] = mAddr[th][k]; mBe[th][k-1] = mBe[th][k];
        mData[th][k-1] = mData[th][k];
      end
      mCnt[th]--;
      @(posedge clk); #1;
      if (mCnt[th] == 0) fenceExp[th] = 1'b0;
    end
    @(negedge clk);
    cmtReady = 1'b0;
    #1;
    chk(cmtValid == 1'b0, "R2 empty after drain", 64'(cmtValid), 64'd0);
    chk(fenceBusy == 2'b00, "R8 fence cleared", 64'(fenceBusy), 64'd0);
  endtask

  task automatic testReset();
    chk(cmtValid == 1'b0, "R2 reset cmtValid", 64'(cmtValid), 64'd0);
    chk(enqFull == 2'b00, "R1 reset enqFull", 64'(enqFull), 64'd0);
    chk(fenceBusy == 2'b00, "R8 reset fenceBusy", 64'(fenceBusy), 64'd0);
  endtask

  task automatic testForward();
    doEnq(0, 32'h10, 8'hFF, 64'h1111_2222_3333_4444);
    doLoad("R3 full forward", 0, 32'h10, 8'hFF, 1'b0, 64'hCCCC_CCCC_CCCC_CCCC);
    doLoad("R3 narrow full forward", 0, 32'h10, 8'h0F, 1'b0, 64'hCCCC_CCCC_CCCC_CCCC);
    doEnq(0, 32'h20, 8'h03, 64'h0000_0000_0000_ABCD);
    doLoad("R4 partial merge", 0, 32'h20, 8'hFF, 1'b0, 64'h8877_6655_4433_2211);
    doEnq(0, 32'h20, 8'h01, 64'h0000_0000_0000_00EE);
    doLoad("R5 youngest wins", 0, 32'h20, 8'hFF, 1'b0, 64'h8877_6655_4433_2211);
    doLoad("R5 youngest full", 0, 32'h20, 8'h01, 1'b0, 64'h8877_6655_4433_2211);
    doLoad("R6 no match", 0, 32'h30, 8'hFF, 1'b0, 64'h0102_0304_0506_0708);
    doLoad("R6 disjoint bytes", 0, 32'h20, 8'hF0, 1'b0, 64'h0102_0304_0506_0708);
    doLoad("R7 other thread", 1, 32'h10, 8'hFF, 1'b0, 64'h5A5A_5A5A_5A5A_5A5A);
    doEnq(1, 32'h10, 8'hF0, 64'h9999_8888_0000_0000);
    doLoad("R7 own thread store", 1, 32'h10, 8'hFF, 1'b0, 64'h5A5A_5A5A_5A5A_5A5A);
    doLoad("R7 t0 unaffected", 0, 32'h10, 8'hFF, 1'b0, 64'h5A5A_5A5A_5A5A_5A5A);
  endtask

  task automatic testCommitHold();
    logic [63:0] d0;
    logic        t0;
    @(negedge clk); #1;
    d0 = cmtData; t0 = cmtThread;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(cmtValid && cmtData == d0 && cmtThread == t0, "R2 hold without ready",
        cmtData, d0);
    drainAll();
  endtask

  task automatic testCapacitySmt();
    for (int i = 0; i < 8; i++)
      doEnq(1, 32'h100 + i, 8'hFF, 64'hA000 + 64'(i));
    @(negedge clk); #1;
    chk(enqFull == 2'b10, "R1 t1 full, t0 free", 64'(enqFull), 64'b10);
    doEnq(1, 32'h200, 8'hFF, 64'hDEAD);   // dropped
    doLoad("R1 dropped store invisible", 1, 32'h200, 8'hFF, 1'b0, 64'h77);
    doEnq(0, 32'h300, 8'h80, 64'hBB00_0000_0000_0000);
    doLoad("R4 t0 merge during t1 full", 0, 32'h300, 8'hC0, 1'b0, 64'h1122_0000_0000_0000);
    drainAll();
  endtask

  task automatic testFence();
    doEnq(0, 32'h40, 8'hFF, 64'h4040_4040_4040_4040);
    doEnq(0, 32'h48, 8'h0F, 64'h0000_0000_4848_4848);
    doFence(0);
    doLoad("R8 load stalled by fence", 0, 32'h40, 8'hFF, 1'b0, 64'hF0F0);
    doEnq(0, 32'h40, 8'hFF, 64'h1234);   // dropped during fence
    doLoad("R8 t1 unaffected", 1, 32'h40, 8'hFF, 1'b0, 64'hF1F1);
    drainAll();
    doLoad("R8 reload sees cache", 0, 32'h40, 8'hFF, 1'b0, 64'hCAFE_F00D);
    doFence(1);   // empty thread: busy never set
  endtask

  task automatic testUncached();
    doEnq(0, 32'h50, 8'hFF, 64'h5050);
    doLoad("R9 uncached stalled", 0, 32'h50, 8'hFF, 1'b1, 64'h0909);
    doLoad("R9 uncached other thread", 1, 32'h50, 8'hFF, 1'b1, 64'h0A0A);
    drainAll();
    doLoad("R9 uncached after drain", 0, 32'h50, 8'hFF, 1'b1, 64'h0B0B);
  endtask

  task automatic testSingleMode();
    @(negedge clk);
    smtMode = 1'b0;
    #1;
    chk(enqFull == 2'b10, "R1 single mode t1 full", 64'(enqFull), 64'b10);
    for (int i = 0; i < 16; i++)
      doEnq(0, 32'h400 + i, 8'hFF, 64'hB000 + 64'(i));
    @(negedge clk); #1;
    chk(enqFull[0] == 1'b1, "R1 single mode 16 entries", 64'(enqFull[0]), 64'd1);
    doEnq(0, 32'h500, 8'hFF, 64'hDEAD);   // dropped
    doEnq(1, 32'h400, 8'hFF, 64'hDEAD);   // dropped, no share
    doLoad("R3 forward from last entry", 0, 32'h40F, 8'hFF, 1'b0, 64'h0);
    doLoad("R7 t1 in single mode", 1, 32'h400, 8'hFF, 1'b0, 64'h0C0C);
    drainAll();
    @(negedge clk);
    smtMode = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; smtMode = 1'b1;
    enqValid = 0; enqThread = 0; enqAddr = '0; enqBe = '0; enqData = '0;
    fenceValid = 0; fenceThread = 0;
    ldValid = 0; ldThread = 0; ldUncached = 0; ldAddr = '0; ldBe = '0;
    cacheRdData = '0; cmtReady = 0;
    mCnt[0] = 0; mCnt[1] = 0; fenceExp[0] = 0; fenceExp[1] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    testForward();
    testCommitHold();
    testCapacitySmt();
    testFence();
    testUncached();
    testSingleMode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule